// File: doc/BRIEF.md
# Register-Cached Evaluation Stack

This block is the operand stack of a stack-oriented execution unit. Software sees a stack with no depth limit. The block keeps only the newest `N` entries in flip-flops and moves older entries to a backing memory. Each command can push a value, discard the top entry, or combine the top two entries with add, subtract, multiply or divide. Arithmetic takes both operands from the stack and puts its single result back on top.

The block uses the backing memory only at the edges of the register window. A push into a full window first evicts the deepest register entry to memory. A pop or arithmetic command that leaves exactly one entry in registers brings the most recently evicted entry back from memory. With this rule, any arithmetic command always finds both operands in registers.

A memory-side stack pointer, counted in entries, addresses the evicted entries. While a memory request is in flight, the block raises `stall`. The block outputs the current top value and two running totals: one counts evictions and one counts refills. A cost model can check these totals against its own figures. Commands that need more entries than the stack holds raise a sticky error flag.

Top module: `eval_stack`

## Requirements
- R1: A PUSH command (cmd_op = 1) accepted at a clock edge makes `top_data` equal to `cmd_data` and sets `top_valid` from that edge onward.
- R2: A POP command (cmd_op = 2) removes the top entry, so that `top_data` shows the entry pushed before it. `top_valid` falls when the stack becomes empty.
- R3: Arithmetic commands replace the two top entries with one result, with the older entry `x` and the top entry `y`. ADD (3) gives x+y, SUB (4) gives x-y, MUL (5) gives the low W bits of x*y, and DIV (6) gives the unsigned quotient x/y, or all ones when y is 0. All results are taken modulo 2^W. Op codes 0 and 7 do nothing.
- R4: A PUSH into a window already holding N entries writes the deepest register entry to memory. The write address equals the count of entries already in memory, that count then increments, and `spill_count` increments by one.
- R5: A POP or arithmetic command that leaves one entry in registers while memory holds entries reads back the entry at address count-1. The count then decrements and `fill_count` increments by one. No other command makes a memory request.
- R6: `stall` is high from the edge that issues a memory request until the edge at which `mem_ready` is seen. During that time `mem_we`, `mem_addr` and `mem_wdata` stay constant, and the block ignores any command presented.
- R7: A POP on an empty stack, or an arithmetic command with fewer than two entries in total, sets `underflow_err`. The stack contents and the counters stay unchanged. The flag stays set until reset.
- R8: With N = 2, evaluating a b c * + a d c * + e - / produces the correct quotient with exactly 4 evictions and 4 refills.
- R9: After reset the stack is empty, the flag and both counters are zero, and no memory request or stall is active.
- R10: Values come back in last-in-first-out order for stack depths below, at, and beyond N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (see R1-R3 for the codes) |
| cmd_data | input | W | Value for PUSH |
| stall | output | 1 | Memory request in flight; commands are ignored |
| top_data | output | W | Current top entry |
| top_valid | output | 1 | Stack is not empty |
| underflow_err | output | 1 | Sticky underflow flag |
| spill_count | output | CW | Evictions since reset |
| fill_count | output | CW | Refills since reset |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_addr | output | AW | Entry address in memory |
| mem_wdata | output | W | Evicted entry |
| mem_rdata | input | W | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | One-cycle completion of the current request |

## Verification
The checks on the refill slot and on request stability rest on one assumption about the memory: it raises `mem_ready` only while a request is pending, for a single cycle, and returns read data in that same cycle. The bench's memory model follows this pattern, with a latency of zero to two cycles that rotates from one request to the next. The stimulus normally waits for `stall` to fall before the next command. Only the stall test deliberately presents a command inside the stall window.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_MUL  = 3'd5,
    OP_DIV  = 3'd6
  } stk_op_e;

  typedef enum logic [2:0] {
    WIN_HOLD,
    WIN_PUSH,
    WIN_POP,
    WIN_REDUCE,
    WIN_FILL
  } win_act_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res
);
  import stk_pkg::*;

  logic [2*W-1:0] prod;

  always_comb begin
    prod = {{W{1'b0}}, lhs} * {{W{1'b0}}, rhs};
    unique case (op)
      OP_SUB:  res = lhs - rhs;
      OP_MUL:  res = prod[W-1:0];
      OP_DIV:  res = (rhs == '0) ? '1 : lhs / rhs;
      default: res = lhs + rhs;
    endcase
  end
endmodule

// File: rtl/stk_window.sv
module stk_window #(
  parameter int W    = 16,
  parameter int N    = 4,
  parameter int CNTW = $clog2(N + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  stk_pkg::win_act_e    act,
  input  logic [W-1:0]         din,
  output logic [W-1:0]         top,
  output logic [W-1:0]         second,
  output logic [W-1:0]         deepest,
  output logic [CNTW-1:0]      count
);
  import stk_pkg::*;

  localparam logic [CNTW-1:0] FULL = CNTW'(N);

  logic [W-1:0] regs  [N];
  logic [W-1:0] nxt   [N];
  logic [W-1:0] up_v  [N];
  logic [W-1:0] dn_v  [N];

  for (genvar i = 0; i < N; i++) begin : g_link
    if (i < N - 1) begin : g_up
      assign up_v[i] = regs[i+1];
    end else begin : g_up_end
      assign up_v[i] = regs[i];
    end
    if (i > 0) begin : g_dn
      assign dn_v[i] = regs[i-1];
    end else begin : g_dn_top
      assign dn_v[i] = din;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      unique case (act)
        WIN_PUSH:   nxt[i] = dn_v[i];
        WIN_POP:    nxt[i] = up_v[i];
        WIN_REDUCE: nxt[i] = (i == 0) ? din : up_v[i];
        WIN_FILL:   nxt[i] = (i == 1) ? din : regs[i];
        default:    nxt[i] = regs[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
      count <= '0;
    end else begin
      for (int i = 0; i < N; i++) regs[i] <= nxt[i];
      unique case (act)
        WIN_PUSH:            if (count != FULL) count <= count + 1'b1;
        WIN_POP, WIN_REDUCE: count <= count - 1'b1;
        WIN_FILL:            count <= count + 1'b1;
        default:             ;
      endcase
    end
  end

  assign top     = regs[0];
  assign second  = regs[1];
  assign deepest = regs[N-1];

  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);
  p_fill_slot_r5: assert property (@(posedge clk) disable iff (rst)
    (act == WIN_FILL) |-> (count == CNTW'(1)));
  p_shrink_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
    (act == WIN_POP || act == WIN_REDUCE) |-> (count != '0));
  p_reduce_pair_r3: assert property (@(posedge clk) disable iff (rst)
    (act == WIN_REDUCE) |-> (count >= CNTW'(2)));
endmodule

// File: rtl/stk_spill.sv
module stk_spill #(
  parameter int W  = 16,
  parameter int AW = 10,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_spill,
  input  logic          start_fill,
  input  logic [W-1:0]  spill_data,
  input  logic          mem_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic          fill_done,
  output logic [AW-1:0] mem_depth,
  output logic [CW-1:0] spill_cnt,
  output logic [CW-1:0] fill_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_depth <= '0;
      spill_cnt <= '0;
      fill_cnt  <= '0;
    end else begin
      if (mem_req && mem_ready) mem_req <= 1'b0;
      if (start_spill) begin
        mem_req   <= 1'b1;
        mem_we    <= 1'b1;
        mem_addr  <= mem_depth;
        mem_wdata <= spill_data;
        mem_depth <= mem_depth + 1'b1;
        spill_cnt <= spill_cnt + 1'b1;
      end else if (start_fill) begin
        mem_req   <= 1'b1;
        mem_we    <= 1'b0;
        mem_addr  <= mem_depth - 1'b1;
        mem_depth <= mem_depth - 1'b1;
        fill_cnt  <= fill_cnt + 1'b1;
      end
    end
  end

  assign fill_done = mem_req && !mem_we && mem_ready;

  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  p_start_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (start_spill || start_fill) |-> !mem_req);
  p_fill_source_r5: assert property (@(posedge clk) disable iff (rst)
    start_fill |-> (mem_depth != '0));
  p_single_start_r5: assert property (@(posedge clk) disable iff (rst)
    !(start_spill && start_fill));
endmodule

// File: rtl/eval_stack.sv
module eval_stack #(
  parameter int W  = 16,
  parameter int N  = 4,
  parameter int AW = 10,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [W-1:0]  cmd_data,
  output logic          stall,
  output logic [W-1:0]  top_data,
  output logic          top_valid,
  output logic          underflow_err,
  output logic [CW-1:0] spill_count,
  output logic [CW-1:0] fill_count,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  input  logic          mem_ready
);
  import stk_pkg::*;

  localparam int CNTW = $clog2(N + 1);
  localparam logic [CNTW-1:0] FULL = CNTW'(N);
  localparam logic [CNTW-1:0] PAIR = CNTW'(2);

  win_act_e        act;
  logic [W-1:0]    win_din;
  logic [W-1:0]    w_top, w_second, w_deepest;
  logic [CNTW-1:0] w_count;
  logic [W-1:0]    alu_res;
  logic            start_spill, start_fill, fill_done, bad_cmd, accept;
  logic [AW-1:0]   mem_depth;

  stk_window #(.W(W), .N(N), .CNTW(CNTW)) u_win (
    .clk(clk), .rst(rst), .act(act), .din(win_din),
    .top(w_top), .second(w_second), .deepest(w_deepest), .count(w_count)
  );

  stk_alu #(.W(W)) u_alu (
    .op(cmd_op), .lhs(w_second), .rhs(w_top), .res(alu_res)
  );

  stk_spill #(.W(W), .AW(AW), .CW(CW)) u_mem (
    .clk(clk), .rst(rst), .start_spill(start_spill), .start_fill(start_fill),
    .spill_data(w_deepest), .mem_ready(mem_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .fill_done(fill_done), .mem_depth(mem_depth),
    .spill_cnt(spill_count), .fill_cnt(fill_count)
  );

  assign accept = cmd_valid && !mem_req;

  always_comb begin
    act         = WIN_HOLD;
    win_din     = cmd_data;
    start_spill = 1'b0;
    start_fill  = 1'b0;
    bad_cmd     = 1'b0;
    if (fill_done) begin
      act     = WIN_FILL;
      win_din = mem_rdata;
    end else if (accept) begin
      unique case (cmd_op)
        OP_PUSH: begin
          act         = WIN_PUSH;
          start_spill = (w_count == FULL);
        end
        OP_POP: begin
          if (w_count == '0) bad_cmd = 1'b1;
          else begin
            act        = WIN_POP;
            start_fill = (w_count == PAIR) && (mem_depth != '0);
          end
        end
        OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
          if (w_count < PAIR) bad_cmd = 1'b1;
          else begin
            act        = WIN_REDUCE;
            win_din    = alu_res;
            start_fill = (w_count == PAIR) && (mem_depth != '0);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          underflow_err <= 1'b0;
    else if (bad_cmd) underflow_err <= 1'b1;
  end

  assign stall     = mem_req;
  assign top_data  = w_top;
  assign top_valid = (w_count != '0);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    underflow_err |=> underflow_err);
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !stall && cmd_op == OP_POP && !top_valid) |=> (!top_valid && underflow_err));
  p_stall_top_r6: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(top_data));
  p_push_top_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !stall && cmd_op == OP_PUSH) |=> (top_valid && top_data == $past(cmd_data)));
endmodule

// File: tb/sim_eval_stack.sv
module sim_eval_stack;
  localparam int CLK_P = 10;
  localparam int W  = 16;
  localparam int N  = 2;
  localparam int AW = 6;
  localparam int CW = 16;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [W-1:0] cmd_data = '0;
  logic stall, top_valid, underflow_err, mem_req, mem_we;
  logic [W-1:0] top_data, mem_wdata;
  logic [W-1:0] mem_rdata = '0;
  logic mem_ready = 1'b0;
  logic [CW-1:0] spill_count, fill_count;
  logic [AW-1:0] mem_addr;

  eval_stack #(.W(W), .N(N), .AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .stall(stall), .top_data(top_data), .top_valid(top_valid), .underflow_err(underflow_err),
    .spill_count(spill_count), .fill_count(fill_count), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  always #(CLK_P/2) clk = ~clk;

  logic [W-1:0] mem [64];
  int lat = 0, lat_next = 0;
  always @(posedge clk) begin
    if (rst) begin
      mem_ready <= 1'b0;
      lat <= 0;
    end else if (mem_req && !mem_ready) begin
      if (lat == 0) begin
        mem_ready <= 1'b1;
        if (mem_we) mem[mem_addr] <= mem_wdata;
        else mem_rdata <= mem[mem_addr];
      end else lat <= lat - 1;
    end else begin
      mem_ready <= 1'b0;
      lat <= lat_next;
      lat_next <= (lat_next + 1) % 3;
    end
  end

  int checks = 0, errors = 0;
  int ref_v [256];
  int sp = 0, er = 0, em = 0, exp_sp = 0, exp_fl = 0, exp_err = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    sp = 0; er = 0; em = 0; exp_sp = 0; exp_fl = 0; exp_err = 0;
  endtask

  task automatic refill();
    if (er == 1 && em > 0) begin er++; em--; exp_fl++; end
  endtask

  task automatic model_apply(input int op, input int data);
    int a, b, r;
    case (op)
      1: begin
        ref_v[sp] = data & MASK; sp++;
        if (er == N) begin em++; exp_sp++; end else er++;
      end
      2: if (sp == 0) exp_err = 1; else begin sp--; er--; refill(); end
      3, 4, 5, 6: if (sp < 2) exp_err = 1; else begin
        a = ref_v[sp-2]; b = ref_v[sp-1];
        case (op)
          3: r = (a + b) & MASK;
          4: r = (a - b) & MASK;
          5: r = int'((longint'(a) * longint'(b)) & MASK);
          default: r = (b == 0) ? MASK : a / b;
        endcase
        ref_v[sp-2] = r; sp--; er--; refill();
      end
      default: ;
    endcase
  endtask

  task automatic issue(input int op, input int data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[2:0]; cmd_data = data[W-1:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    while (stall) @(negedge clk);
  endtask

  task automatic do_op(input string tag, input int op, input int data);
    issue(op, data);
    model_apply(op, data);
    check({tag, " top_valid"}, top_valid, sp > 0);
    if (sp > 0) check({tag, " top_data"}, top_data, ref_v[sp-1]);
    check({tag, " R4 spill_count"}, spill_count, exp_sp);
    check({tag, " R5 fill_count"}, fill_count, exp_fl);
    check({tag, " R7 underflow_err"}, underflow_err, exp_err);
  endtask

  task automatic do_reset();
    rst = 1'b1; cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int vals [6];
    vals[0] = 0; vals[1] = 1; vals[2] = 3; vals[3] = 'h7F; vals[4] = 'hFFFF; vals[5] = 'h1234;

    // R9 reset state
    do_reset();
    check("R9 top_valid", top_valid, 0);
    check("R9 underflow_err", underflow_err, 0);
    check("R9 spill_count", spill_count, 0);
    check("R9 fill_count", fill_count, 0);
    check("R9 mem_req", mem_req, 0);
    check("R9 stall", stall, 0);

    // R8 expression trace: a=3 b=4 c=5 d=2 e=1 -> 23/12 = 1
    do_op("R8 push a", 1, 3);
    do_op("R8 push b", 1, 4);
    do_op("R8 push c", 1, 5);
    do_op("R8 mul", 5, 0);
    do_op("R8 add", 3, 0);
    do_op("R8 push a", 1, 3);
    do_op("R8 push d", 1, 2);
    do_op("R8 push c", 1, 5);
    do_op("R8 mul", 5, 0);
    do_op("R8 add", 3, 0);
    do_op("R8 push e", 1, 1);
    do_op("R8 sub", 4, 0);
    do_op("R8 div", 6, 0);
    check("R8 result", top_data, 1);
    check("R8 stores", spill_count, 4);
    check("R8 fetches", fill_count, 4);
    do_op("R2 pop last", 2, 0);

    // R10 LIFO sweep over depths below, at and beyond the window (R1 R2 R4 R5)
    for (int d = 1; d <= 6; d++) begin
      for (int k = 0; k < d; k++) do_op("R10 R1 push", 1, d * 16 + k);
      for (int k = 0; k < d; k++) do_op("R10 R2 pop", 2, 0);
    end

    // R3 arithmetic sweep on top of two base entries (forces spill and refill)
    do_op("R3 base", 1, 'hAAAA);
    do_op("R3 base", 1, 'h5555);
    for (int ia = 0; ia < 6; ia++)
      for (int ib = 0; ib < 6; ib++)
        for (int op = 3; op <= 6; op++) begin
          do_op("R3 push x", 1, vals[ia]);
          do_op("R3 push y", 1, vals[ib]);
          do_op("R3 arith", op, 0);
          do_op("R3 pop", 2, 0);
        end
    do_op("R3 nop", 0, 'h77);
    do_op("R3 code7", 7, 'h77);

    // R6 stall window: a spilling push, with a stray command inside the stall
    begin
      int before_sp;
      before_sp = sp;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd1; cmd_data = 16'h0C0D;
      @(negedge clk);
      check("R6 stall raised", stall, 1);
      check("R4 write request", mem_we, 1);
      check("R4 write address", mem_addr, em);
      check("R4 evicted value", mem_wdata, ref_v[before_sp - N]);
      cmd_data = 16'hBEEF;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (stall) @(negedge clk);
      model_apply(1, 'h0C0D);
      check("R6 stray ignored top", top_data, 'h0C0D);
      check("R6 stray ignored spills", spill_count, exp_sp);
      do_op("R6 pop after stall", 2, 0);
    end

    // R5 refill read address observed on the port
    do_op("R5 push", 1, 'h0101);
    do_op("R5 push", 1, 'h0202);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R5 read request", mem_we, 0);
    check("R5 read address", mem_addr, em - 1);
    while (stall) @(negedge clk);
    model_apply(2, 0);
    check("R5 refilled fill_count", fill_count, exp_fl);
    check("R5 refilled top", top_data, ref_v[sp-1]);

    // R7 underflow: drain, then illegal commands
    while (sp > 0) do_op("R7 drain", 2, 0);
    do_op("R7 pop empty", 2, 0);
    do_op("R7 push one", 1, 9);
    do_op("R7 add short", 3, 0);
    do_op("R7 div short", 6, 0);
    check("R7 top kept", top_data, 9);
    do_op("R7 pop one", 2, 0);
    do_op("R7 sticky", 1, 4);
    do_reset();
    check("R9 flag cleared", underflow_err, 0);

    finish_run();
  end
endmodule